// File: doc/BRIEF.md
# Sub-Cycle Phase Strobe Generator

This block drives a set of active-low external control strobes with a resolution finer than one bus clock. It runs on a fast internal clock and splits each bus cycle into up to four phases, T1 to T4. For every strobe, the current pattern word holds four bits, one per phase. The block steps through those bits and drives each strobe to the level its bit asks for in the current phase.

A two-bit divider code sets the bus cycle length to 2, 4 or 8 fast-clock cycles. With the longer settings all four phase bits take effect. With the shortest setting a bus cycle has only two phases: T1 is the first half and T3 is the second half. The T2 and T4 bits are then ignored, so a quarter-phase change in the word comes out as a half-cycle change.

The block samples the pattern word and the divider code only at the start of T1. It reports the phase it is driving and pulses a done flag on the last fast-clock cycle of every bus cycle. A sequencer can use that pulse to present the next word. Choosing words and generating addresses belong to that sequencer and are not part of this block.

Top module: `strobe_phase_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every `strobe_n` bit is 1 (deasserted), `phase` is 0 and `cycle_done` is 0.
- R2: `div_sel` 2'b00 gives a bus cycle of 2 fast-clock cycles, 2'b01 gives 4 and 2'b10 or 2'b11 gives 8. The code is sampled only at the start of T1, so a change made during a bus cycle first acts on the next bus cycle.
- R3: With a cycle of 8, `phase` runs 0,0,1,1,2,2,3,3: each phase T1..T4 lasts two fast-clock cycles.
- R4: With a cycle of 4, `phase` runs 0,1,2,3: each phase lasts one fast-clock cycle.
- R5: With a cycle of 2, `phase` runs 0,2 (T1, then T3). Word bits for T2 and T4 have no effect on any strobe.
- R6: For strobe s in phase p (p=0 is T1, p=3 is T4), the controlling bit is `word_in[s*4+p]`. A 1 drives `strobe_n[s]` low and a 0 drives it high.
- R7: `word_in` is sampled only at the start of T1. Changes during the rest of the bus cycle have no effect until the next bus cycle.
- R8: `cycle_done` is 1 for exactly the output cycle that shows the last phase of a bus cycle. The next output cycle shows `phase` 0.
- R9: All outputs are registered. The values seen after a clock edge reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Divider code: 00 = 2, 01 = 4, 10/11 = 8 fast cycles per bus cycle |
| word_in | input | NUM_SIG*4 | Pattern word: four phase bits per strobe |
| strobe_n | output | NUM_SIG | Active-low strobe levels |
| phase | output | 2 | Phase being driven (0 = T1 .. 3 = T4) |
| cycle_done | output | 1 | High on the last fast cycle of each bus cycle |

## Verification
The assertions assume that `rst` is applied at start-up, so the tick counter begins at T1. They also assume that `div_sel` and `word_in` are stable around each rising edge. Under these conditions a bus cycle can never run past the length picked at its start, and phases never step backwards within a bus cycle. The bench changes its inputs only on the falling edge. It changes `div_sel` and `word_in` at arbitrary points inside bus cycles, including the reserved code 11, so that the sampling at T1 is exercised rather than assumed.

// File: rtl/strobe_phase_pkg.sv
package strobe_phase_pkg;

    localparam int PHASES = 4;
    localparam int TICK_W = 3;

    typedef enum logic [1:0] {
        DIV_2   = 2'b00,
        DIV_4   = 2'b01,
        DIV_8   = 2'b10,
        DIV_8_R = 2'b11
    } div_code_e;

    // index of the final fast tick of a bus cycle
    function automatic logic [TICK_W-1:0] last_tick(input logic [1:0] code);
        case (div_code_e'(code))
            DIV_2:   last_tick = 3'd1;
            DIV_4:   last_tick = 3'd3;
            default: last_tick = 3'd7;
        endcase
    endfunction

    // map a fast tick to the phase slot T1..T4 (0..3)
    function automatic logic [1:0] tick_phase(input logic [1:0] code,
                                              input logic [TICK_W-1:0] tick);
        case (div_code_e'(code))
            DIV_2:   tick_phase = {tick[0], 1'b0};
            DIV_4:   tick_phase = tick[1:0];
            default: tick_phase = tick[2:1];
        endcase
    endfunction

endpackage

// File: rtl/spg_phase_counter.sv
module spg_phase_counter
    import strobe_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_in,
    output logic       start,
    output logic [1:0] eff_phase,
    output logic [1:0] phase_q,
    output logic       done_q
);

    logic [TICK_W-1:0] tick;
    logic [1:0]        held_div;
    logic [1:0]        eff_div;
    logic              at_last;

    assign start     = (tick == '0);
    assign eff_div   = start ? div_in : held_div;
    assign at_last   = (tick == last_tick(eff_div));
    assign eff_phase = tick_phase(eff_div, tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick     <= '0;
            held_div <= 2'b00;
            phase_q  <= 2'd0;
            done_q   <= 1'b0;
        end else begin
            if (start) begin
                held_div <= div_in;
            end
            tick    <= at_last ? '0 : tick + 3'd1;
            phase_q <= eff_phase;
            done_q  <= at_last;
        end
    end

    // R2: a running bus cycle never exceeds the length chosen at its T1
    p_tick_range_r2: assert property (@(posedge clk) disable iff (rst)
        !start |-> (tick <= last_tick(held_div)));

    // R8: the output cycle after the done pulse shows T1
    p_t1_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> (phase_q == 2'd0));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R3: phases never step backwards within a bus cycle
    p_phase_order_r3: assert property (@(posedge clk) disable iff (rst)
        !done_q |=> (phase_q >= $past(phase_q)));

endmodule

// File: rtl/spg_strobe_drive.sv
module spg_strobe_drive
    import strobe_phase_pkg::*;
#(
    parameter int NUM_SIG = 4,
    localparam int WORD_W = NUM_SIG * PHASES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [1:0]        phase_sel,
    output logic [NUM_SIG-1:0] strobe_n
);

    logic [WORD_W-1:0] held_word;
    logic [WORD_W-1:0] eff_word;

    assign eff_word = load ? word_in : held_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_word <= '0;
        end else if (load) begin
            held_word <= word_in;
        end
    end

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
        logic [PHASES-1:0] slots;
        assign slots = eff_word[s*PHASES +: PHASES];

        always_ff @(posedge clk) begin
            if (rst) begin
                strobe_n[s] <= 1'b1;
            end else begin
                strobe_n[s] <= ~slots[phase_sel];
            end
        end
    end

    // R1: strobes leave reset deasserted
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&strobe_n));

endmodule

// File: rtl/strobe_phase_gen.sv
module strobe_phase_gen
    import strobe_phase_pkg::*;
#(
    parameter int NUM_SIG = 4,
    localparam int WORD_W = NUM_SIG * PHASES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         div_sel,
    input  logic [WORD_W-1:0]  word_in,
    output logic [NUM_SIG-1:0] strobe_n,
    output logic [1:0]         phase,
    output logic               cycle_done
);

    logic       t1_start;
    logic [1:0] cur_phase;

    spg_phase_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .div_in    (div_sel),
        .start     (t1_start),
        .eff_phase (cur_phase),
        .phase_q   (phase),
        .done_q    (cycle_done)
    );

    spg_strobe_drive #(.NUM_SIG(NUM_SIG)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .load      (t1_start),
        .word_in   (word_in),
        .phase_sel (cur_phase),
        .strobe_n  (strobe_n)
    );

endmodule

// File: tb/strobe_phase_gen_tb.sv
`timescale 1ns/1ps
module strobe_phase_gen_tb;

    localparam int NS = 4;
    localparam int WW = NS * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    div_sel = 2'b10;
    logic [WW-1:0] word_in = '0;
    logic [NS-1:0] strobe_n;
    logic [1:0]    phase;
    logic          cycle_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model state
    int            m_tick = 0;
    int            m_div = 0;
    logic [WW-1:0] m_word = '0;
    logic [NS-1:0] e_strobe = '1;
    int            e_phase = 0;
    bit            e_done = 0;

    always #2 clk = ~clk;

    strobe_phase_gen #(.NUM_SIG(NS)) u_dut (
        .clk(clk), .rst(rst), .div_sel(div_sel), .word_in(word_in),
        .strobe_n(strobe_n), .phase(phase), .cycle_done(cycle_done)
    );

    function automatic int len_of(input int code);
        return (code == 0) ? 2 : (code == 1) ? 4 : 8;
    endfunction

    function automatic int slot_of(input int code, input int t);
        if (code == 0) return t * 2;      // T1, T3
        if (code == 1) return t;
        return t / 2;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // one clock: advance the model at the edge, compare at the falling edge
    task automatic step();
        int len;
        int p;
        @(posedge clk);
        if (rst) begin
            m_tick = 0; e_strobe = '1; e_phase = 0; e_done = 0;
        end else begin
            if (m_tick == 0) begin
                m_word = word_in;
                m_div  = int'(div_sel);
            end
            len = len_of(m_div);
            p   = slot_of(m_div, m_tick);
            for (int s = 0; s < NS; s++) e_strobe[s] = !m_word[s*4+p];
            e_phase = p;
            e_done  = (m_tick == len - 1);
            m_tick  = e_done ? 0 : m_tick + 1;
        end
        @(negedge clk);
        check(tag, int'(strobe_n), int'(e_strobe));
        check(tag, int'(phase), e_phase);
        check("R8", int'(cycle_done), int'(e_done));
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) step();
        check("R1", int'(strobe_n), 4'hF);
        check("R1", int'(phase), 0);
        check("R1", int'(cycle_done), 0);
        rst = 1'b0;
        step();
        check("R1", int'(strobe_n), 4'hF);
        check("R1", int'(phase), 0);

        // R3: divide by 8
        tag = "R3";
        div_sel = 2'b10;
        for (int i = 0; i < 48; i++) begin
            word_in = WW'(16'h5A3C ^ (i * 16'h1357));
            step();
        end

        // R4: divide by 4
        tag = "R4";
        div_sel = 2'b01;
        for (int i = 0; i < 40; i++) begin
            word_in = WW'(16'hC3E1 + i * 16'h0F1D);
            step();
        end

        // R5: divide by 2, only T2/T4 bits set: strobes must stay high
        tag = "R5";
        div_sel = 2'b00;
        word_in = 16'hAAAA;
        repeat (4) step();
        for (int i = 0; i < 12; i++) begin
            step();
            check("R5", int'(strobe_n), 4'hF);
        end
        for (int i = 0; i < 30; i++) begin
            word_in = WW'($urandom);
            step();
        end

        // R6: single bit: strobe 2 in T3 (bit 10), divide by 4
        tag = "R6";
        div_sel = 2'b01;
        word_in = 16'h0400;
        repeat (8) step();
        for (int i = 0; i < 4; i++) begin
            step();
            check("R6", int'(strobe_n), (phase == 2'd2) ? 4'hB : 4'hF);
        end

        // R2: divider changes at arbitrary points, reserved code included
        tag = "R2";
        for (int i = 0; i < 300; i++) begin
            div_sel = 2'($urandom);
            word_in = WW'($urandom);
            step();
        end

        // R7: word changes every cycle under a fixed divider
        tag = "R7";
        div_sel = 2'b11;
        for (int i = 0; i < 200; i++) begin
            word_in = WW'($urandom);
            step();
        end

        // R9 / R1: reset mid-cycle then recover
        tag = "R9";
        div_sel = 2'b10;
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        for (int i = 0; i < 40; i++) begin
            word_in = WW'($urandom);
            step();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule